// File: doc/BRIEF.md
# Watch Interval Timer with Tone Output

This block is a free-running prescaler counter that advances once for each period of a 32.768 kHz watch clock. The watch clock arrives as a one-cycle enable pulse (`wclk_tick`) in the system clock domain. One counter serves two purposes. When a selected low-order field of the counter wraps, the block raises a sticky interval flag. Four low-order counter bits also serve as square-wave taps for a tone output. At the default parameters the long interval is 16384 ticks (0.5 s) and the short interval is 128 ticks (about 3.9 ms). The taps divide the watch clock by 16, 8, 4 or 2, which gives 2, 4, 8 or 16 kHz.

Software programs the block through a single control write. The write carries a run enable, a counter clear, the interval choice, a two-bit tone select and a tone enable. The flag is a polled event: it stays set until software acknowledges it. It does not raise a vectored interrupt.

Top module: `watch_tone_timer`

## Requirements
- R1: After reset the counter is zero, the flag is low, the tone output is low, and every control field is zero (not running, short interval, tone select 0, tone disabled).
- R2: On each clock edge where the stored run bit is 1 and `wclk_tick` is 1, the counter advances by one, modulo 2^CNT_W. On every other edge the counter holds its value.
- R3: A control write with `cfg_clr`=1 sets the counter to zero on that edge. The clear overrides any advance, and no interval event is produced on that edge.
- R4: With `cfg_long`=0, the flag rises on the edge where an advance takes the low SHORT_LOG2 counter bits from all ones to zero. After a clear this is the 128th advance.
- R5: With `cfg_long`=1, the flag rises only when the whole CNT_W-bit counter wraps. After a clear this is the 16384th advance, and the short-field wrap at advance 128 leaves the flag low.
- R6: Once set, the flag stays set until a cycle with `flag_ack`=1 clears it on the next edge. If a new interval event falls on the same edge as the acknowledge, the flag stays set.
- R7: Tone select value s (0..3) drives `tone_out` from counter bit 3-s. Value 0 divides the tick rate by 16, 1 by 8, 2 by 4 and 3 by 2.
- R8: While the stored tone enable is 0, `tone_out` is held low whatever the counter holds.
- R9: The control fields are stored only on an edge where `cfg_we`=1. A change on the field inputs without `cfg_we` has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wclk_tick | input | 1 | One-cycle pulse per watch-clock period |
| cfg_we | input | 1 | Control write strobe |
| cfg_run | input | 1 | Run enable field |
| cfg_clr | input | 1 | Counter clear field, acts only during the write |
| cfg_long | input | 1 | Interval select: 1 long, 0 short |
| cfg_tone_sel | input | 2 | Tone tap select |
| cfg_tone_en | input | 1 | Tone output enable |
| flag_ack | input | 1 | Clears the interval flag |
| wt_flag | output | 1 | Sticky interval flag |
| tone_out | output | 1 | Square-wave tone |

## Verification
The bench checks the exact edge on which each interval fires: advance 127 against advance 128, and advance 16383 against advance 16384. A design with an off-by-one wrap compare, or with the interval select inverted, would raise the flag one edge early, one edge late, or at the wrong length. For every tone select, it sweeps the counter through many values and compares the output with the arithmetically expected bit, so a reversed tap order shows up at once. It also drives an acknowledge on the same edge as an interval event, which catches an acknowledge given priority over the set. It toggles the field inputs without a write strobe and holds off ticks while the block runs, which catches fields latched without the strobe or a counter that advances without a tick.

// File: rtl/wt_pkg.sv
package wt_pkg;

   localparam int TONE_SEL_W = 2;
   localparam int N_TONES    = 1 << TONE_SEL_W;

   typedef struct packed {
      logic                  run;
      logic                  long_ivl;
      logic [TONE_SEL_W-1:0] tone_sel;
      logic                  tone_en;
   } wt_cfg_t;

   localparam wt_cfg_t WT_CFG_RESET = '{run: 1'b0, long_ivl: 1'b0,
                                        tone_sel: '0, tone_en: 1'b0};

endpackage

// File: rtl/wt_prescaler.sv
module wt_prescaler #(
   parameter int CNT_W      = 14,
   parameter int SHORT_LOG2 = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run,
   input  logic             clr,
   input  logic             long_sel,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap_evt
);

   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   generate
      if (SHORT_LOG2 < 1 || SHORT_LOG2 >= CNT_W) begin : g_bad_short
         $error("wt_prescaler: SHORT_LOG2 must lie in 1..CNT_W-1");
      end
   endgenerate

   logic adv;
   logic short_full;
   logic long_full;

   assign adv        = run & tick;
   assign short_full = &cnt[SHORT_LOG2-1:0];
   assign long_full  = &cnt;
   assign wrap_evt   = adv & ~clr & (long_sel ? long_full : short_full);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else if (adv) cnt <= cnt + ONE;
   end

   AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0)); // R3
   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !clr) |=> (cnt == $past(cnt) + ONE)); // R2
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !clr) |=> $stable(cnt)); // R2

endmodule

// File: rtl/wt_tone_tap.sv
module wt_tone_tap #(
   parameter int CNT_W    = 14,
   parameter int TAP_LOW  = 0,
   parameter int SEL_W    = 2
) (
   input  logic [CNT_W-1:0] cnt,
   input  logic [SEL_W-1:0] sel,
   input  logic             en,
   output logic             tone
);

   localparam int N_TAPS = 1 << SEL_W;

   generate
      if (TAP_LOW < 0 || TAP_LOW + N_TAPS > CNT_W) begin : g_bad_tap
         $error("wt_tone_tap: tap range exceeds the counter");
      end
   endgenerate

   logic [N_TAPS-1:0] taps;

   genvar gi;
   generate
      for (gi = 0; gi < N_TAPS; gi++) begin : g_tap
         assign taps[gi] = cnt[TAP_LOW + N_TAPS - 1 - gi];
      end
   endgenerate

   assign tone = en & taps[sel];

endmodule

// File: rtl/wt_flag.sv
module wt_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic ack,
   output logic flag
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flag <= 1'b0;
      else if (set) flag <= 1'b1;
      else if (ack) flag <= 1'b0;
   end

   AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> flag); // R6
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !ack) |=> flag); // R6
   AST_FLAG_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag && !set) |=> !flag); // R4

endmodule

// File: rtl/watch_tone_timer.sv
module watch_tone_timer #(
   parameter int CNT_W      = 14,
   parameter int SHORT_LOG2 = 7,
   parameter int TAP_LOW    = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wclk_tick,
   input  logic       cfg_we,
   input  logic       cfg_run,
   input  logic       cfg_clr,
   input  logic       cfg_long,
   input  logic [1:0] cfg_tone_sel,
   input  logic       cfg_tone_en,
   input  logic       flag_ack,
   output logic       wt_flag,
   output logic       tone_out
);

   import wt_pkg::*;

   wt_cfg_t          cfg_q;
   logic [CNT_W-1:0] cnt;
   logic             wrap_evt;
   logic             clr_now;

   assign clr_now = cfg_we & cfg_clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= WT_CFG_RESET;
      end else if (cfg_we) begin
         cfg_q.run      <= cfg_run;
         cfg_q.long_ivl <= cfg_long;
         cfg_q.tone_sel <= cfg_tone_sel;
         cfg_q.tone_en  <= cfg_tone_en;
      end
   end

   wt_prescaler #(.CNT_W(CNT_W), .SHORT_LOG2(SHORT_LOG2)) u_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (wclk_tick),
      .run      (cfg_q.run),
      .clr      (clr_now),
      .long_sel (cfg_q.long_ivl),
      .cnt      (cnt),
      .wrap_evt (wrap_evt)
   );

   wt_tone_tap #(.CNT_W(CNT_W), .TAP_LOW(TAP_LOW), .SEL_W(TONE_SEL_W)) u_tap (
      .cnt  (cnt),
      .sel  (cfg_q.tone_sel),
      .en   (cfg_q.tone_en),
      .tone (tone_out)
   );

   wt_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (wrap_evt),
      .ack   (flag_ack),
      .flag  (wt_flag)
   );

   AST_TONE_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_q.tone_en |-> !tone_out); // R8
   AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> $stable(cfg_q)); // R9

endmodule

// File: tb/watch_tone_timer_tb.sv
module watch_tone_timer_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wclk_tick = 1'b0;
   logic       cfg_we = 1'b0;
   logic       cfg_run = 1'b0;
   logic       cfg_clr = 1'b0;
   logic       cfg_long = 1'b0;
   logic [1:0] cfg_tone_sel = 2'd0;
   logic       cfg_tone_en = 1'b0;
   logic       flag_ack = 1'b0;
   logic       wt_flag;
   logic       tone_out;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   watch_tone_timer u_dut (
      .clk(clk), .rst_n(rst_n), .wclk_tick(wclk_tick), .cfg_we(cfg_we),
      .cfg_run(cfg_run), .cfg_clr(cfg_clr), .cfg_long(cfg_long),
      .cfg_tone_sel(cfg_tone_sel), .cfg_tone_en(cfg_tone_en),
      .flag_ack(flag_ack), .wt_flag(wt_flag), .tone_out(tone_out)
   );

   task automatic chk(input bit act, input bit exp, input string req);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0b expected=%0b time=%0t", req, act, exp, $time);
      end
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input bit run, input bit clr, input bit lng,
                     input logic [1:0] sel, input bit en);
      cfg_we = 1'b1; cfg_run = run; cfg_clr = clr; cfg_long = lng;
      cfg_tone_sel = sel; cfg_tone_en = en;
      step(1);
      cfg_we = 1'b0; cfg_clr = 1'b0;
   endtask

   // Stop, clear, acknowledge, then start with counter at zero.
   task automatic restart(input bit lng, input logic [1:0] sel, input bit en);
      wr(1'b0, 1'b1, lng, sel, en);
      flag_ack = 1'b1; step(1); flag_ack = 1'b0;
      wr(1'b1, 1'b0, lng, sel, en);
   endtask

   initial begin
      step(3);
      // R1: reset state
      chk(wt_flag, 1'b0, "R1 flag after reset");
      chk(tone_out, 1'b0, "R1 tone after reset");
      rst_n = 1'b1;
      step(2);
      // R1: not running after reset: ticks do nothing; enable tone at bit0 tap
      wclk_tick = 1'b1;
      wr(1'b0, 1'b0, 1'b0, 2'd3, 1'b1);
      step(5);
      chk(tone_out, 1'b0, "R1 counter zero, not running");

      // R7/R2: tone sweep, tone = bit (3-s) of advance count n
      for (int s = 0; s < 4; s++) begin
         restart(1'b0, s[1:0], 1'b1);
         for (int n = 0; n < 40; n++) begin
            chk(tone_out, ((n >> (3 - s)) & 1) != 0, "R7 tone tap");
            step(1);
         end
      end

      // R8: tone disabled stays low through a sweep
      restart(1'b0, 2'd3, 1'b0);
      for (int n = 0; n < 20; n++) begin
         chk(tone_out, 1'b0, "R8 tone muted");
         step(1);
      end

      // R9: field inputs without strobe have no effect (count 20 now, bit0 tap)
      cfg_tone_en = 1'b1;
      step(1);
      chk(tone_out, 1'b0, "R9 enable without strobe ignored");
      cfg_tone_en = 1'b0;

      // R2: no advance without tick; bit0 tap
      restart(1'b0, 2'd3, 1'b1);
      wclk_tick = 1'b0;
      step(5);
      chk(tone_out, 1'b0, "R2 hold without tick");
      wclk_tick = 1'b1; step(1); wclk_tick = 1'b0;
      chk(tone_out, 1'b1, "R2 one tick one advance");
      step(4);
      chk(tone_out, 1'b1, "R2 hold after tick");
      wclk_tick = 1'b1;
      // R2: run off freezes count (count 2 after this write edge? run was on)
      wr(1'b0, 1'b0, 1'b0, 2'd3, 1'b1);
      step(4);
      chk(tone_out, 1'b0, "R2 hold with run off (count 2)");

      // R3: clear while running, count resets to zero
      restart(1'b0, 2'd2, 1'b1);
      step(6);
      chk(tone_out, 1'b1, "R3 pre-clear count 6 bit1");
      wr(1'b1, 1'b1, 1'b0, 2'd2, 1'b1);
      chk(tone_out, 1'b0, "R3 count zero after clear");
      step(2);
      chk(tone_out, 1'b1, "R3 count 2 after clear");

      // R4: short interval fires on advance 128
      restart(1'b0, 2'd0, 1'b0);
      step(127);
      chk(wt_flag, 1'b0, "R4 no flag at 127");
      step(1);
      chk(wt_flag, 1'b1, "R4 flag at 128");
      // R6: sticky
      step(50);
      chk(wt_flag, 1'b1, "R6 flag sticky");
      flag_ack = 1'b1; step(1); flag_ack = 1'b0;
      chk(wt_flag, 1'b0, "R6 ack clears");
      // count now 179; next event at 256: ack on that edge, set wins
      step(76);
      flag_ack = 1'b1; step(1); flag_ack = 1'b0;
      chk(wt_flag, 1'b1, "R6 set beats ack");
      flag_ack = 1'b1; step(1); flag_ack = 1'b0;
      chk(wt_flag, 1'b0, "R6 later ack clears");

      // R3: clear on an event edge suppresses the event (count 127 -> clear)
      restart(1'b0, 2'd0, 1'b0);
      step(127);
      wr(1'b1, 1'b1, 1'b0, 2'd0, 1'b0);
      chk(wt_flag, 1'b0, "R3 clear suppresses event");

      // R5: long interval
      restart(1'b1, 2'd0, 1'b0);
      step(128);
      chk(wt_flag, 1'b0, "R5 short wrap ignored");
      step(16383 - 128);
      chk(wt_flag, 1'b0, "R5 no flag at 16383");
      step(1);
      chk(wt_flag, 1'b1, "R5 flag at 16384");

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (60000) @(posedge clk);
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=done");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule